// File: doc/BRIEF.md
# Trigger Window Hit Filter

This block sits between a stream of time-stamped channel hits and the event builder. It decides which hits belong to the current trigger. Each hit carries a channel number and a 28-bit coarse timestamp taken from a free-running counter. When a trigger is accepted, the block records the counter value. It then forwards only those hits whose stamps lie between a programmable distance before the trigger and a programmable distance after it. Once the counter has moved past the far edge, the block emits a one-cycle window-closed pulse and holds until the event is released.

With windowing switched off, the block streams freely: every hit on an enabled channel is forwarded. A trigger then closes the event at once. In this mode a light option can flag that the header and reference word should be dropped when nothing was recorded. A per-channel word budget caps how many hits each channel contributes to an event. The budget keeps the earliest hits, and a budget value of 128 or more lifts the cap.

Top module: `trig_window_filter`

## Requirements
- R1: In free-streaming mode, a hit on an enabled channel that is within its budget appears on `out_vld`, `out_chan` and `out_ts` on the clock edge after it is presented.
- R2: The enable of channel c is bit c of `chan_mask_lo` for c below 32, and bit c-32 of `chan_mask_hi` otherwise. A hit on a disabled channel never produces `out_vld`.
- R3: In windowed mode, a hit passes only while the window is open and only if (hit_ts - (T - back)) mod 2^28 <= back + ahead, where T is the trigger stamp. Hits presented while idle or after closure are dropped.
- R4: A programmed look-ahead below 15 counts is used as 15.
- R5: `win_done` is a one-cycle pulse. In windowed mode it follows the edge on which (ts_now - T) mod 2^28 >= ahead. In free-streaming mode it follows the edge that accepts the trigger.
- R6: Each channel forwards at most `cfg_limit` hits between releases, keeping the first ones. A limit of 128 or more means no cap. Counts clear on release.
- R7: `hdr_keep` is high only together with `win_done`. It is always 1 for a windowed event. In free-streaming mode it is 0 only when `cfg_light` is set and no hit has passed since the last release, counting the trigger cycle.
- R8: A trigger is accepted only while idle; triggers while open or after closure are ignored. `trig_rel` acts only after closure and returns the block to idle.
- R9: Look-back, look-ahead, window enable, light option and limit are captured when the trigger is accepted. Later changes do not alter the event in progress. The channel masks act live.
- R10: All window arithmetic is modulo 2^28, so windows that straddle counter wrap behave the same as any other window.
- R11: While reset is held, all outputs are 0 and the block is idle with cleared budgets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_now | input | 28 | Free-running coarse counter |
| hit_vld | input | 1 | Hit strobe |
| hit_chan | input | 6 | Channel of the hit (0..63) |
| hit_ts | input | 28 | Coarse stamp of the hit |
| trig | input | 1 | Trigger strobe |
| trig_rel | input | 1 | Event release |
| cfg_lookback | input | 11 | Look-back width in counts |
| cfg_lookahead | input | 11 | Look-ahead width in counts |
| cfg_win_en | input | 1 | 1 = windowed, 0 = free streaming |
| cfg_light | input | 1 | Suppress header of empty free-streaming events |
| cfg_limit | input | 8 | Per-channel hit budget, 128 and up = unlimited |
| chan_mask_lo | input | 32 | Enables of channels 0..31 |
| chan_mask_hi | input | 32 | Enables of channels 32..63 |
| out_vld | output | 1 | Forwarded hit strobe |
| out_chan | output | 6 | Channel of the forwarded hit |
| out_ts | output | 28 | Stamp of the forwarded hit |
| win_done | output | 1 | Window-closed pulse |
| hdr_keep | output | 1 | Emit header for this event |

## Verification
The bench aims hits at both edges of the window and one count outside each. A filter with an off-by-one compare would drop an edge hit or admit the neighbour outside. A look-ahead of 3 is programmed, and the bench confirms that nothing closes after ten cycles. A design without the clamp would close far too early.

One window is placed across the counter wrap. Plain unsigned compares would reject the hits after zero there. Budget runs of four hits against a limit of two must keep the first two stamps; a design that overwrote would report the later ones. The bench also sends triggers during an open and a closed window, and changes the configuration mid-window. A design that re-armed or read the live registers would pulse `win_done` twice or close at the wrong time.

// File: rtl/twf_pkg.sv
package twf_pkg;
  typedef enum logic [1:0] {
    TWF_IDLE = 2'd0,
    TWF_OPEN = 2'd1,
    TWF_DONE = 2'd2
  } twf_state_e;
endpackage

// File: rtl/twf_window_cmp.sv
// Modular window arithmetic: hit membership and end-of-window detection.
module twf_window_cmp #(
  parameter int TS_W  = 28,
  parameter int WIN_W = 11
) (
  input  logic [TS_W-1:0]  ts_now,
  input  logic [TS_W-1:0]  hit_ts,
  input  logic [TS_W-1:0]  trig_ts,
  input  logic [WIN_W-1:0] back_w,
  input  logic [WIN_W-1:0] ahead_w,
  output logic             in_win,
  output logic             reached_end
);
  localparam int SPAN_W = WIN_W + 1;

  logic [SPAN_W-1:0] span;
  logic [TS_W-1:0]   lo_edge;
  logic [TS_W-1:0]   hit_off;
  logic [TS_W-1:0]   elapsed;

  always_comb begin
    span        = {1'b0, back_w} + {1'b0, ahead_w};
    lo_edge     = trig_ts - TS_W'(back_w);
    hit_off     = hit_ts - lo_edge;
    elapsed     = ts_now - trig_ts;
    in_win      = hit_off <= TS_W'(span);
    reached_end = elapsed >= TS_W'(ahead_w);
  end
endmodule

// File: rtl/twf_chan_budget.sv
// Per-channel hit counters; earliest hits consume the budget.
module twf_chan_budget #(
  parameter int CHANS   = 64,
  parameter int LIM_W   = 8,
  parameter int LIM_INF = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     bump,
  input  logic [$clog2(CHANS)-1:0] sel,
  input  logic [LIM_W-1:0]         limit,
  output logic                     room
);
  localparam int CH_W = $clog2(CHANS);

  logic [LIM_W-1:0] cnt_q [CHANS];

  for (genvar g = 0; g < CHANS; g++) begin : g_cnt
    logic             cnt_en;
    logic [LIM_W-1:0] cnt_d;

    always_comb begin
      cnt_en = clr || (bump && (sel == CH_W'(g)) && (cnt_q[g] != '1));
      cnt_d  = clr ? '0 : cnt_q[g] + LIM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (cnt_en) cnt_q[g] <= cnt_d;
    end
  end

  always_comb begin
    room = (limit >= LIM_W'(LIM_INF)) || (cnt_q[sel] < limit);
  end
endmodule

// File: rtl/twf_ctrl.sv
// Event sequencer: trigger capture, window close, release, header decision.
module twf_ctrl
  import twf_pkg::*;
#(
  parameter int TS_W   = 28,
  parameter int WIN_W  = 11,
  parameter int LIM_W  = 8,
  parameter int LA_MIN = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             trig_rel,
  input  logic [TS_W-1:0]  ts_now,
  input  logic [WIN_W-1:0] cfg_back,
  input  logic [WIN_W-1:0] cfg_ahead,
  input  logic             cfg_win_en,
  input  logic             cfg_light,
  input  logic [LIM_W-1:0] cfg_limit,
  input  logic             reached_end,
  input  logic             pass_now,
  output twf_state_e       state,
  output logic [TS_W-1:0]  trig_ts,
  output logic [WIN_W-1:0] back_w,
  output logic [WIN_W-1:0] ahead_w,
  output logic             win_on,
  output logic [LIM_W-1:0] limit_q,
  output logic             clr_budget,
  output logic             done,
  output logic             hdr
);
  twf_state_e       st_q, st_d;
  logic             take, close_now;
  logic             any_q, any_d;
  logic             done_d, hdr_d;
  logic [WIN_W-1:0] ahead_clamped;

  always_comb begin
    take          = (st_q == TWF_IDLE) && trig;
    close_now     = (st_q == TWF_OPEN) && reached_end;
    clr_budget    = (st_q == TWF_DONE) && trig_rel;
    ahead_clamped = (cfg_ahead < WIN_W'(LA_MIN)) ? WIN_W'(LA_MIN) : cfg_ahead;

    st_d = st_q;
    unique case (st_q)
      TWF_IDLE: if (take)       st_d = cfg_win_en ? TWF_OPEN : TWF_DONE;
      TWF_OPEN: if (close_now)  st_d = TWF_DONE;
      TWF_DONE: if (clr_budget) st_d = TWF_IDLE;
      default:                  st_d = TWF_IDLE;
    endcase

    if (clr_budget)    any_d = 1'b0;
    else if (pass_now) any_d = 1'b1;
    else               any_d = any_q;

    done_d = (take && !cfg_win_en) || close_now;
    hdr_d  = close_now ||
             (take && !cfg_win_en && (!cfg_light || any_q || pass_now));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TWF_IDLE;
      any_q <= 1'b0;
      done  <= 1'b0;
      hdr   <= 1'b0;
    end else begin
      st_q  <= st_d;
      any_q <= any_d;
      done  <= done_d;
      hdr   <= hdr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_ts <= '0;
      back_w  <= '0;
      ahead_w <= WIN_W'(LA_MIN);
      win_on  <= 1'b0;
      limit_q <= '0;
    end else if (take) begin
      trig_ts <= ts_now;
      back_w  <= cfg_back;
      ahead_w <= ahead_clamped;
      win_on  <= cfg_win_en;
      limit_q <= cfg_limit;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/trig_window_filter.sv
module trig_window_filter
  import twf_pkg::*;
#(
  parameter int CHANS   = 64,
  parameter int TS_W    = 28,
  parameter int WIN_W   = 11,
  parameter int LIM_W   = 8,
  parameter int LA_MIN  = 15,
  parameter int LIM_INF = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [TS_W-1:0]          ts_now,
  input  logic                     hit_vld,
  input  logic [$clog2(CHANS)-1:0] hit_chan,
  input  logic [TS_W-1:0]          hit_ts,
  input  logic                     trig,
  input  logic                     trig_rel,
  input  logic [WIN_W-1:0]         cfg_lookback,
  input  logic [WIN_W-1:0]         cfg_lookahead,
  input  logic                     cfg_win_en,
  input  logic                     cfg_light,
  input  logic [LIM_W-1:0]         cfg_limit,
  input  logic [CHANS/2-1:0]       chan_mask_lo,
  input  logic [CHANS/2-1:0]       chan_mask_hi,
  output logic                     out_vld,
  output logic [$clog2(CHANS)-1:0] out_chan,
  output logic [TS_W-1:0]          out_ts,
  output logic                     win_done,
  output logic                     hdr_keep
);
  localparam int CH_W = $clog2(CHANS);

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q, rst_meta} <= 2'b00;
    else        {rst_q, rst_meta} <= {rst_meta, 1'b1};
  end

  twf_state_e       state;
  logic [TS_W-1:0]  trig_ts;
  logic [WIN_W-1:0] back_w, ahead_w;
  logic             win_on, clr_budget, room, in_win, reached_end;
  logic [LIM_W-1:0] limit_q, eff_limit;
  logic             in_idle, free_mode, pass;
  logic [CHANS-1:0] chan_en;

  always_comb begin
    chan_en   = {chan_mask_hi, chan_mask_lo};
    in_idle   = (state == TWF_IDLE);
    free_mode = in_idle ? !cfg_win_en : !win_on;
    eff_limit = in_idle ? cfg_limit : limit_q;
    pass      = hit_vld && chan_en[hit_chan] && room &&
                (free_mode || ((state == TWF_OPEN) && in_win));
  end

  twf_window_cmp #(.TS_W(TS_W), .WIN_W(WIN_W)) u_cmp (
    .ts_now      (ts_now),
    .hit_ts      (hit_ts),
    .trig_ts     (trig_ts),
    .back_w      (back_w),
    .ahead_w     (ahead_w),
    .in_win      (in_win),
    .reached_end (reached_end)
  );

  twf_chan_budget #(.CHANS(CHANS), .LIM_W(LIM_W), .LIM_INF(LIM_INF)) u_budget (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (clr_budget),
    .bump  (pass),
    .sel   (hit_chan),
    .limit (eff_limit),
    .room  (room)
  );

  twf_ctrl #(.TS_W(TS_W), .WIN_W(WIN_W), .LIM_W(LIM_W), .LA_MIN(LA_MIN)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_q),
    .trig        (trig),
    .trig_rel    (trig_rel),
    .ts_now      (ts_now),
    .cfg_back    (cfg_lookback),
    .cfg_ahead   (cfg_lookahead),
    .cfg_win_en  (cfg_win_en),
    .cfg_light   (cfg_light),
    .cfg_limit   (cfg_limit),
    .reached_end (reached_end),
    .pass_now    (pass),
    .state       (state),
    .trig_ts     (trig_ts),
    .back_w      (back_w),
    .ahead_w     (ahead_w),
    .win_on      (win_on),
    .limit_q     (limit_q),
    .clr_budget  (clr_budget),
    .done        (win_done),
    .hdr         (hdr_keep)
  );

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) out_vld <= 1'b0;
    else        out_vld <= pass;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_chan <= '0;
      out_ts   <= '0;
    end else if (pass) begin
      out_chan <= hit_chan;
      out_ts   <= hit_ts;
    end
  end
endmodule

// File: rtl/twf_checker.sv
module twf_checker #(
  parameter int CHANS = 64,
  parameter int TS_W  = 28
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     hit_vld,
  input logic [$clog2(CHANS)-1:0] hit_chan,
  input logic [TS_W-1:0]          hit_ts,
  input logic [CHANS/2-1:0]       chan_mask_lo,
  input logic [CHANS/2-1:0]       chan_mask_hi,
  input logic                     out_vld,
  input logic [$clog2(CHANS)-1:0] out_chan,
  input logic [TS_W-1:0]          out_ts,
  input logic                     win_done,
  input logic                     hdr_keep
);
  logic [CHANS-1:0] all_en;
  assign all_en = {chan_mask_hi, chan_mask_lo};

  AST_ECHO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> ($past(hit_vld) && out_chan == $past(hit_chan) && out_ts == $past(hit_ts))); // R1

  AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vld && !all_en[hit_chan]) |=> !out_vld); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done); // R5

  AST_HDR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_keep |-> win_done); // R7
endmodule

bind trig_window_filter twf_checker #(.CHANS(CHANS), .TS_W(TS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q),
  .hit_vld      (hit_vld),
  .hit_chan     (hit_chan),
  .hit_ts       (hit_ts),
  .chan_mask_lo (chan_mask_lo),
  .chan_mask_hi (chan_mask_hi),
  .out_vld      (out_vld),
  .out_chan     (out_chan),
  .out_ts       (out_ts),
  .win_done     (win_done),
  .hdr_keep     (hdr_keep)
);

// File: tb/sim_trig_window_filter.sv
module sim_trig_window_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [27:0] ts_now;
  logic        hit_vld;
  logic [5:0]  hit_chan;
  logic [27:0] hit_ts;
  logic        trig, trig_rel;
  logic [10:0] cfg_lookback, cfg_lookahead;
  logic        cfg_win_en, cfg_light;
  logic [7:0]  cfg_limit;
  logic [31:0] chan_mask_lo, chan_mask_hi;
  logic        out_vld;
  logic [5:0]  out_chan;
  logic [27:0] out_ts;
  logic        win_done, hdr_keep;

  trig_window_filter u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk or negedge rst_n)
    if (!rst_n) ts_now <= 28'hFFFF000;
    else        ts_now <= ts_now + 28'd1;

  int n_chk = 0, n_bad = 0;
  int pass_seen = 0, done_seen = 0;
  bit run = 0, hdr_last = 0;
  logic [27:0] last_ts;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // behavioural reference model
  int          m_st, m_lb, m_la, m_lim;
  logic [27:0] m_T;
  bit          m_win, m_any;
  int          m_cnt [64];
  bit          e_vld, e_done, e_hdr;
  logic [5:0]  e_chan;
  logic [27:0] e_ts;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_any = 0; m_T = 0; m_lb = 0; m_la = 15; m_lim = 128; m_win = 0;
      foreach (m_cnt[i]) m_cnt[i] = 0;
      e_vld = 0; e_done = 0; e_hdr = 0; e_chan = 0; e_ts = 0;
    end else begin
      bit free, en, lim_ok, inwin, pass;
      int lim;
      logic [27:0] off, el;
      free   = (m_st == 0) ? !cfg_win_en : !m_win;
      lim    = (m_st == 0) ? int'(cfg_limit) : m_lim;
      en     = (hit_chan < 32) ? chan_mask_lo[hit_chan[4:0]] : chan_mask_hi[hit_chan[4:0]];
      lim_ok = (lim >= 128) || (m_cnt[hit_chan] < lim);
      off    = hit_ts - (m_T - 28'(m_lb));
      inwin  = (m_st == 1) && (int'(off) <= m_lb + m_la);
      pass   = hit_vld && en && lim_ok && (free || inwin);
      e_vld  = pass;
      if (pass) begin e_chan = hit_chan; e_ts = hit_ts; end
      if (m_st == 2 && trig_rel) begin
        foreach (m_cnt[i]) m_cnt[i] = 0;
        m_any = 0;
      end else if (pass) begin
        if (m_cnt[hit_chan] < 255) m_cnt[hit_chan]++;
        m_any = 1;
      end
      e_done = 0; e_hdr = 0;
      if (m_st == 0) begin
        if (trig) begin
          m_T = ts_now; m_lb = cfg_lookback;
          m_la = (cfg_lookahead < 15) ? 15 : int'(cfg_lookahead);
          m_win = cfg_win_en; m_lim = cfg_limit;
          if (cfg_win_en) m_st = 1;
          else begin m_st = 2; e_done = 1; e_hdr = !cfg_light || m_any; end
        end
      end else if (m_st == 1) begin
        el = ts_now - m_T;
        if (int'(el) >= m_la) begin m_st = 2; e_done = 1; e_hdr = 1; end
      end else if (trig_rel) m_st = 0;
    end
  end

  always @(negedge clk) if (run) begin
    chk(out_vld === e_vld, "R3 out_vld vs model", out_vld, e_vld);
    if (e_vld) begin
      chk(out_chan === e_chan, "R1 out_chan", out_chan, e_chan);
      chk(out_ts === e_ts, "R1 out_ts", out_ts, e_ts);
    end
    chk(win_done === e_done, "R5 win_done vs model", win_done, e_done);
    chk(hdr_keep === e_hdr, "R7 hdr_keep vs model", hdr_keep, e_hdr);
    if (out_vld) begin pass_seen++; last_ts = out_ts; end
    if (win_done) begin done_seen++; hdr_last = hdr_keep; end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic hit(int ch, logic [27:0] ts);
    hit_vld = 1; hit_chan = 6'(ch); hit_ts = ts; tick(); hit_vld = 0;
  endtask
  task automatic pulse_trig(); trig = 1; tick(); trig = 0; endtask
  task automatic pulse_rel();  trig_rel = 1; tick(); trig_rel = 0; endtask
  task automatic wait_n(int n); for (int i = 0; i < n; i++) tick(); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [27:0] t0;
    rst_n = 0; hit_vld = 0; hit_chan = 0; hit_ts = 0; trig = 0; trig_rel = 0;
    cfg_lookback = 0; cfg_lookahead = 15; cfg_win_en = 0; cfg_light = 0;
    cfg_limit = 8'h80; chan_mask_lo = '1; chan_mask_hi = 32'hFFFF_FEFF;
    wait_n(3);
    chk(out_vld == 0 && win_done == 0 && hdr_keep == 0, "R11 reset outputs",
        {out_vld, win_done, hdr_keep}, 0);
    chk(out_ts == 0 && out_chan == 0, "R11 reset data", out_ts, 0);
    rst_n = 1; run = 1;
    wait_n(4);

    // R2: channel 40 = hi bit 8 disabled
    pass_seen = 0;
    for (int i = 0; i < 3; i++) hit(40, 28'(i));
    tick();
    chk(pass_seen == 0, "R2 disabled channel 40", pass_seen, 0);
    // R1: free streaming
    pass_seen = 0;
    for (int i = 0; i < 5; i++) hit(3, 28'(100 + i));
    hit(63, 28'h1234);
    tick();
    chk(pass_seen == 6, "R1 free-stream hits", pass_seen, 6);
    chk(last_ts == 28'h1234, "R1 last stamp ch63", last_ts, 28'h1234);
    done_seen = 0;
    pulse_trig(); tick();
    chk(done_seen == 1 && hdr_last == 1, "R5 free close, R7 header kept", done_seen, 1);
    pulse_rel();

    // R7: light mode, empty event
    cfg_light = 1; done_seen = 0; hdr_last = 1;
    pulse_trig(); tick();
    chk(done_seen == 1 && hdr_last == 0, "R7 light empty header dropped", hdr_last, 0);
    pulse_rel();
    hit(3, 28'd7); pulse_trig(); tick();
    chk(hdr_last == 1, "R7 light non-empty header kept", hdr_last, 1);
    pulse_rel();

    // R6: limit 2 keeps earliest
    cfg_limit = 8'd2; pass_seen = 0;
    for (int i = 0; i < 4; i++) hit(5, 28'(200 + i));
    tick();
    chk(pass_seen == 2, "R6 limit count", pass_seen, 2);
    chk(last_ts == 28'd201, "R6 earliest kept", last_ts, 201);
    pulse_trig(); tick(); pulse_rel();
    pass_seen = 0; hit(5, 28'd300); tick();
    chk(pass_seen == 1, "R6 count cleared by release", pass_seen, 1);
    pulse_trig(); tick(); pulse_rel();
    cfg_limit = 8'h80; pass_seen = 0;
    for (int i = 0; i < 130; i++) hit(6, 28'(i));
    tick();
    chk(pass_seen == 130, "R6 unlimited at 0x80", pass_seen, 130);
    pulse_trig(); tick(); pulse_rel();

    // R3/R4: windowed, back 10, ahead 3 -> 15
    cfg_win_en = 1; cfg_lookback = 10; cfg_lookahead = 3; cfg_light = 1;
    pass_seen = 0; hit(3, ts_now); tick();
    chk(pass_seen == 0, "R3 idle windowed drop", pass_seen, 0);
    done_seen = 0; t0 = ts_now;
    pulse_trig();
    hit(3, t0 - 28'd10); hit(3, t0 - 28'd11); hit(3, t0 + 28'd15);
    hit(3, t0 + 28'd16); hit(3, t0);
    wait_n(4);
    chk(pass_seen == 3, "R3 window edges", pass_seen, 3);
    chk(done_seen == 0, "R4 lookahead clamped, still open", done_seen, 0);
    wait_n(10);
    chk(done_seen == 1 && hdr_last == 1, "R5 window closed, R7 header", done_seen, 1);
    // R8: trigger during closure ignored
    pass_seen = 0; pulse_trig(); hit(3, t0); wait_n(20);
    chk(done_seen == 1, "R8 trigger after close ignored", done_seen, 1);
    chk(pass_seen == 0, "R3 hit after close dropped", pass_seen, 0);
    pulse_rel();
    pulse_trig(); wait_n(3); pulse_trig(); wait_n(20);
    chk(done_seen == 2, "R8 trigger while open ignored", done_seen, 2);
    pulse_rel();

    // R9: mid-window config change
    cfg_lookback = 0; cfg_lookahead = 15; pass_seen = 0; t0 = ts_now;
    pulse_trig();
    cfg_lookahead = 200; cfg_win_en = 0;
    hit(3, t0 + 28'd100); wait_n(20);
    chk(done_seen == 3, "R9 close uses captured ahead", done_seen, 3);
    chk(pass_seen == 0, "R9 captured window mode", pass_seen, 0);
    cfg_win_en = 1; pulse_rel();

    // R10: window across wrap
    cfg_lookback = 0; cfg_lookahead = 20; pass_seen = 0;
    while (ts_now != 28'hFFFFFFA) tick();
    pulse_trig();
    hit(3, 28'h0000005); hit(3, 28'hFFFFFF9); hit(3, 28'h000000E); hit(3, 28'h000000F);
    wait_n(25);
    chk(pass_seen == 2, "R10 wrap membership", pass_seen, 2);
    chk(done_seen == 4, "R10 wrap close", done_seen, 4);
    pulse_rel(); wait_n(3);
    finish_run();
  end
endmodule